// File: doc/BRIEF.md
# Stereo codec mixer control registers

This block is the control register file of a stereo audio codec's output mixer. A host reaches it through a 7-bit register index, a write strobe and 16-bit data. Reads are combinational from the index. Four locations are implemented:

- a capability register, which is read-only;
- the master output volume register;
- an extension control register;
- a general 16-bit storage register.

Every other index reads back as zero and ignores writes.

From the stored state the block drives a 5-bit attenuation code and a mute flag for each of four outputs: left, right, center and LFE. Each code step is 1.5 dB, so codes 0 to 31 cover 0 dB to 46.5 dB.

A 6-bit volume value whose top bit is written as 1 saturates to full attenuation. A write of any value to the capability index restores the volume and extension registers to their defaults. The storage register keeps its contents through this. Two flags in the extension register change how the outputs are driven:

- The split flag separates the right mute from the shared mute.
- The follow flag copies the line settings onto the center and LFE outputs.

Top module: `codec_regbank`

## Requirements
- R1: A read of index 00h returns 0090h.
- R2: A write of any value to index 00h sets index 02h to 8000h and index 76h to 0000h from the next cycle on; index 74h keeps its contents.
- R3: While rst_ni is low, index 02h reads 8000h, and indices 74h and 76h read 0000h. Left and right are muted with code 0. Center and LFE show code 0 with mute clear.
- R4: When bit 13 (left) or bit 5 (right) of a write to index 02h is 1, the lower five bits of that 6-bit volume field are stored as ones. The field reads back as 3Fh and its attenuation code becomes 31.
- R5: The left volume occupies bits 13:8 of index 02h and the right volume occupies bits 5:0. Each attenuation output equals the low five bits of its stored field, one code per 1.5 dB step. Outputs reflect a write from the cycle after the write edge.
- R6: While the split flag (bit 12 of index 76h) is 0, bit 15 of index 02h mutes both left and right. Bit 7 reads 0, and a 1 written to bit 7 is not stored.
- R7: While the split flag is 1, bit 15 mutes only the left output and bit 7 stores and drives the right mute.
- R8: While the follow flag (bit 11 of index 76h) is 1, center carries the left code and mute, and LFE carries the right code and mute. While it is 0, center and LFE show code 0 with mute clear.
- R9: These locations read as zero and ignore writes: bits 14 and 6 of index 02h, every bit of index 76h other than 12 and 11, and every unimplemented index.
- R10: Index 74h stores and returns all 16 bits written to it. Only rst_ni clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| addr_i | input | 7 | Register index |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| att_left_o | output | 5 | Left attenuation code |
| att_right_o | output | 5 | Right attenuation code |
| att_center_o | output | 5 | Center attenuation code |
| att_lfe_o | output | 5 | LFE attenuation code |
| mute_left_o | output | 1 | Left mute |
| mute_right_o | output | 1 | Right mute |
| mute_center_o | output | 1 | Center mute |
| mute_lfe_o | output | 1 | LFE mute |

## Verification
Every write lands on the rising edge where the strobe is seen. Read data, attenuation codes and mute flags all reflect that write within the same cycle after the edge. The read path has no register, so rdata_o follows addr_i with no clock latency. The bench drives inputs on the falling edge and applies each write across exactly one rising edge. It then samples reads and outputs on the next falling edge, half a cycle after the state register has loaded. Reset-index checks use the same timing, which confirms that the default values appear one edge after the write.

// File: rtl/codec_regbank_pkg.sv
package codec_regbank_pkg;
  localparam int DATA_W = 16;

  localparam logic [6:0] IDX_CAPS   = 7'h00;
  localparam logic [6:0] IDX_MASTER = 7'h02;
  localparam logic [6:0] IDX_SPARE  = 7'h74;
  localparam logic [6:0] IDX_EXT    = 7'h76;

  localparam logic [DATA_W-1:0] CAPS_CODE = 16'h0090;

  localparam int MUTE_BIT   = 15;
  localparam int LEFT_LSB   = 8;
  localparam int RMUTE_BIT  = 7;
  localparam int RIGHT_LSB  = 0;
  localparam int SPLIT_BIT  = 12;
  localparam int FOLLOW_BIT = 11;

  typedef struct packed {
    logic split;
    logic follow;
  } ext_flags_t;
endpackage

// File: rtl/codec_vol_field.sv
module codec_vol_field #(
  parameter int VOL_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_clr_i,
  input  logic             we_i,
  input  logic [VOL_W-1:0] d_i,
  output logic [VOL_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         q_o <= '0;
    else if (soft_clr_i) q_o <= '0;
    else if (we_i)       q_o <= d_i[VOL_W-1] ? '1 : d_i;
  end

  AST_VOL_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !soft_clr_i && d_i[VOL_W-1]) |=> (&q_o)); // R4
endmodule

// File: rtl/codec_master_reg.sv
module codec_master_reg
  import codec_regbank_pkg::*;
#(
  parameter int VOL_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_clr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              split_i,
  output logic [VOL_W-1:0]  vol_left_o,
  output logic [VOL_W-1:0]  vol_right_o,
  output logic              mute_o,
  output logic              rmute_o,
  output logic [DATA_W-1:0] rd_o
);
  localparam int NCH = 2;
  localparam int LSB [NCH] = '{LEFT_LSB, RIGHT_LSB};

  logic [VOL_W-1:0] vol_q [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    codec_vol_field #(.VOL_W(VOL_W)) u_field (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .soft_clr_i(soft_clr_i),
      .we_i      (we_i),
      .d_i       (wdata_i[LSB[c] +: VOL_W]),
      .q_o       (vol_q[c])
    );
  end

  logic mute_q, rmute_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mute_q  <= 1'b1;
      rmute_q <= 1'b0;
    end else if (soft_clr_i) begin
      mute_q  <= 1'b1;
      rmute_q <= 1'b0;
    end else if (we_i) begin
      mute_q  <= wdata_i[MUTE_BIT];
      rmute_q <= wdata_i[RMUTE_BIT] & split_i;  // dropped unless split is on
    end
  end

  assign vol_left_o  = vol_q[0];
  assign vol_right_o = vol_q[1];
  assign mute_o      = mute_q;
  assign rmute_o     = rmute_q & split_i;

  always_comb begin
    rd_o = '0;
    rd_o[MUTE_BIT]                 = mute_q;
    rd_o[LEFT_LSB +: VOL_W]        = vol_q[0];
    rd_o[RMUTE_BIT]                = rmute_q & split_i;
    rd_o[RIGHT_LSB +: VOL_W]       = vol_q[1];
  end
endmodule

// File: rtl/codec_ext_reg.sv
module codec_ext_reg
  import codec_regbank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_clr_i,
  input  logic              ext_we_i,
  input  logic              spare_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ext_flags_t        flags_o,
  output logic [DATA_W-1:0] ext_rd_o,
  output logic [DATA_W-1:0] spare_rd_o
);
  ext_flags_t        flags_q;
  logic [DATA_W-1:0] spare_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flags_q <= '0;
    else if (soft_clr_i) flags_q <= '0;
    else if (ext_we_i) begin
      flags_q.split  <= wdata_i[SPLIT_BIT];
      flags_q.follow <= wdata_i[FOLLOW_BIT];
    end
  end

  // spared by the soft reset: hardware reset only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         spare_q <= '0;
    else if (spare_we_i) spare_q <= wdata_i;
  end

  assign flags_o    = flags_q;
  assign spare_rd_o = spare_q;

  always_comb begin
    ext_rd_o             = '0;
    ext_rd_o[SPLIT_BIT]  = flags_q.split;
    ext_rd_o[FOLLOW_BIT] = flags_q.follow;
  end

  AST_SPARE_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_clr_i && !spare_we_i) |=> $stable(spare_q)); // R2
endmodule

// File: rtl/codec_out_map.sv
module codec_out_map #(
  parameter int VOL_W = 6,
  localparam int ATT_W = VOL_W - 1
) (
  input  logic [VOL_W-1:0] vol_left_i,
  input  logic [VOL_W-1:0] vol_right_i,
  input  logic             mute_i,
  input  logic             rmute_i,
  input  logic             split_i,
  input  logic             follow_i,
  output logic [ATT_W-1:0] att_left_o,
  output logic [ATT_W-1:0] att_right_o,
  output logic [ATT_W-1:0] att_center_o,
  output logic [ATT_W-1:0] att_lfe_o,
  output logic             mute_left_o,
  output logic             mute_right_o,
  output logic             mute_center_o,
  output logic             mute_lfe_o
);
  // saturated fields already carry all-ones low bits
  assign att_left_o   = vol_left_i[ATT_W-1:0];
  assign att_right_o  = vol_right_i[ATT_W-1:0];
  assign mute_left_o  = mute_i;
  assign mute_right_o = split_i ? rmute_i : mute_i;

  assign att_center_o  = follow_i ? att_left_o   : '0;
  assign att_lfe_o     = follow_i ? att_right_o  : '0;
  assign mute_center_o = follow_i & mute_left_o;
  assign mute_lfe_o    = follow_i & mute_right_o;
endmodule

// File: rtl/codec_regbank.sv
module codec_regbank
  import codec_regbank_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int VOL_W  = 6,
  localparam int ATT_W = VOL_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ATT_W-1:0]  att_left_o,
  output logic [ATT_W-1:0]  att_right_o,
  output logic [ATT_W-1:0]  att_center_o,
  output logic [ATT_W-1:0]  att_lfe_o,
  output logic              mute_left_o,
  output logic              mute_right_o,
  output logic              mute_center_o,
  output logic              mute_lfe_o
);
  logic hit_caps, hit_master, hit_ext, hit_spare;
  assign hit_caps   = addr_i == ADDR_W'(IDX_CAPS);
  assign hit_master = addr_i == ADDR_W'(IDX_MASTER);
  assign hit_ext    = addr_i == ADDR_W'(IDX_EXT);
  assign hit_spare  = addr_i == ADDR_W'(IDX_SPARE);

  logic soft_clr;
  assign soft_clr = wr_en_i & hit_caps;

  ext_flags_t        flags;
  logic [DATA_W-1:0] master_rd, ext_rd, spare_rd;
  logic [VOL_W-1:0]  vol_l, vol_r;
  logic              mute_m, rmute;

  codec_master_reg #(.VOL_W(VOL_W)) u_master (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_clr_i (soft_clr),
    .we_i       (wr_en_i & hit_master),
    .wdata_i    (wdata_i),
    .split_i    (flags.split),
    .vol_left_o (vol_l),
    .vol_right_o(vol_r),
    .mute_o     (mute_m),
    .rmute_o    (rmute),
    .rd_o       (master_rd)
  );

  codec_ext_reg u_ext (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .soft_clr_i(soft_clr),
    .ext_we_i  (wr_en_i & hit_ext),
    .spare_we_i(wr_en_i & hit_spare),
    .wdata_i   (wdata_i),
    .flags_o   (flags),
    .ext_rd_o  (ext_rd),
    .spare_rd_o(spare_rd)
  );

  codec_out_map #(.VOL_W(VOL_W)) u_map (
    .vol_left_i   (vol_l),
    .vol_right_i  (vol_r),
    .mute_i       (mute_m),
    .rmute_i      (rmute),
    .split_i      (flags.split),
    .follow_i     (flags.follow),
    .att_left_o   (att_left_o),
    .att_right_o  (att_right_o),
    .att_center_o (att_center_o),
    .att_lfe_o    (att_lfe_o),
    .mute_left_o  (mute_left_o),
    .mute_right_o (mute_right_o),
    .mute_center_o(mute_center_o),
    .mute_lfe_o   (mute_lfe_o)
  );

  always_comb begin
    rdata_o = '0;
    if (hit_caps)   rdata_o = CAPS_CODE;
    if (hit_master) rdata_o = master_rd;
    if (hit_ext)    rdata_o = ext_rd;
    if (hit_spare)  rdata_o = spare_rd;
  end

  AST_SOFT_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_clr |=> (mute_left_o && mute_right_o && att_left_o == '0 &&
                  att_right_o == '0 && !flags.split && !flags.follow)); // R2
  AST_SHARED_MUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flags.split |-> (mute_right_o == mute_left_o)); // R6
  AST_FOLLOW_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flags.follow |-> (att_center_o == '0 && att_lfe_o == '0 &&
                       !mute_center_o && !mute_lfe_o)); // R8
  AST_FOLLOW_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags.follow |-> (att_center_o == att_left_o && att_lfe_o == att_right_o &&
                      mute_center_o == mute_left_o && mute_lfe_o == mute_right_o)); // R8
  AST_MASTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && hit_master && !wdata_i[13] && !wdata_i[5]) |=>
      (att_left_o == $past(wdata_i[12:8]) && att_right_o == $past(wdata_i[4:0]))); // R5
endmodule

// File: tb/codec_regbank_bench.sv
module codec_regbank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [4:0]  att_l, att_r, att_c, att_f;
  logic        m_l, m_r, m_c, m_f;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  codec_regbank u_codec_regbank (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata),
    .att_left_o(att_l), .att_right_o(att_r), .att_center_o(att_c), .att_lfe_o(att_f),
    .mute_left_o(m_l), .mute_right_o(m_r), .mute_center_o(m_c), .mute_lfe_o(m_f)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [6:0] a, input logic [15:0] exp);
    addr = a;
    #1;
    check(tag, rdata, exp);
  endtask

  // {mute_l,mute_r,mute_c,mute_f}
  task automatic out_chk(input string tag, input logic [4:0] el, input logic [4:0] er,
                         input logic [4:0] ec, input logic [4:0] ef, input logic [3:0] em);
    check(tag, {11'd0, att_l}, {11'd0, el});
    check(tag, {11'd0, att_r}, {11'd0, er});
    check(tag, {11'd0, att_c}, {11'd0, ec});
    check(tag, {11'd0, att_f}, {11'd0, ef});
    check(tag, {12'd0, m_l, m_r, m_c, m_f}, {12'd0, em});
  endtask

  task automatic t_reset_state;
    rd_chk("R3 master", 7'h02, 16'h8000);
    rd_chk("R3 ext", 7'h76, 16'h0000);
    rd_chk("R3 spare", 7'h74, 16'h0000);
    out_chk("R3 outputs", 5'd0, 5'd0, 5'd0, 5'd0, 4'b1100);
  endtask

  task automatic t_caps;
    rd_chk("R1 caps", 7'h00, 16'h0090);
  endtask

  task automatic t_volume;
    wr(7'h02, 16'h0A05);
    rd_chk("R5 readback", 7'h02, 16'h0A05);
    out_chk("R5 codes", 5'd10, 5'd5, 5'd0, 5'd0, 4'b0000);
    wr(7'h02, 16'h1F00);
    out_chk("R5 max code", 5'd31, 5'd0, 5'd0, 5'd0, 4'b0000);
  endtask

  task automatic t_saturate;
    wr(7'h02, 16'h2110);
    rd_chk("R4 left sat", 7'h02, 16'h3F10);
    out_chk("R4 left code", 5'd31, 5'd16, 5'd0, 5'd0, 4'b0000);
    wr(7'h02, 16'h0025);
    rd_chk("R4 right sat", 7'h02, 16'h003F);
    out_chk("R4 right code", 5'd0, 5'd31, 5'd0, 5'd0, 4'b0000);
  endtask

  task automatic t_split;
    wr(7'h02, 16'h8080);
    rd_chk("R6 bit7 reads 0", 7'h02, 16'h8000);
    out_chk("R6 shared mute", 5'd0, 5'd0, 5'd0, 5'd0, 4'b1100);
    wr(7'h76, 16'h1000);
    rd_chk("R6 bit7 not stored", 7'h02, 16'h8000);
    out_chk("R7 left only", 5'd0, 5'd0, 5'd0, 5'd0, 4'b1000);
    wr(7'h02, 16'h0080);
    rd_chk("R7 rmute read", 7'h02, 16'h0080);
    out_chk("R7 right only", 5'd0, 5'd0, 5'd0, 5'd0, 4'b0100);
    wr(7'h76, 16'h0000);
    rd_chk("R6 masked again", 7'h02, 16'h0000);
    out_chk("R6 unmuted", 5'd0, 5'd0, 5'd0, 5'd0, 4'b0000);
  endtask

  task automatic t_follow;
    wr(7'h76, 16'h0800);
    wr(7'h02, 16'h0C03);
    out_chk("R8 follow codes", 5'd12, 5'd3, 5'd12, 5'd3, 4'b0000);
    wr(7'h02, 16'h8C03);
    out_chk("R8 follow mute", 5'd12, 5'd3, 5'd12, 5'd3, 4'b1111);
    wr(7'h76, 16'h0000);
    out_chk("R8 follow off", 5'd12, 5'd3, 5'd0, 5'd0, 4'b1100);
  endtask

  task automatic t_reserved;
    wr(7'h76, 16'hFFFF);
    rd_chk("R9 ext bits", 7'h76, 16'h1800);
    wr(7'h02, 16'h4040);
    rd_chk("R9 master reserved", 7'h02, 16'h0000);
    wr(7'h74, 16'h1234);
    wr(7'h10, 16'hFFFF);
    rd_chk("R9 unused read", 7'h10, 16'h0000);
    rd_chk("R9 master kept", 7'h02, 16'h0000);
    rd_chk("R9 ext kept", 7'h76, 16'h1800);
    rd_chk("R9 spare kept", 7'h74, 16'h1234);
    out_chk("R9 outputs kept", 5'd0, 5'd0, 5'd0, 5'd0, 4'b0000);
  endtask

  task automatic t_spare;
    wr(7'h74, 16'hA5C3);
    rd_chk("R10 spare", 7'h74, 16'hA5C3);
  endtask

  task automatic t_soft_reset;
    wr(7'h02, 16'h0A0A);
    wr(7'h00, 16'h0000);
    rd_chk("R2 master default", 7'h02, 16'h8000);
    rd_chk("R2 ext default", 7'h76, 16'h0000);
    rd_chk("R2 spare kept", 7'h74, 16'hA5C3);
    out_chk("R2 outputs", 5'd0, 5'd0, 5'd0, 5'd0, 4'b1100);
    rd_chk("R1 caps after", 7'h00, 16'h0090);
  endtask

  task automatic t_hw_reset;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    rd_chk("R10 hw clear", 7'h74, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_caps();
    t_volume();
    t_saturate();
    t_split();
    t_follow();
    t_reserved();
    t_spare();
    t_soft_reset();
    t_hw_reset();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule